// File: doc/BRIEF.md
# Boundary-Scan Interconnect Test Master

This block runs a single interconnect test over a daisy-chained boundary register that sits between device pins. On an accepted start request it produces the test clock from the system clock and steps the chained TAP controllers through a fixed route. First it forces every controller to its reset state. Next it loads a fixed instruction that places the boundary cells between the serial input and output. It then shifts a drive vector into the cells and applies it to the pins with an update step. A second pass captures the pin levels and shifts them back out.

The read-back vector is compared with an expected vector, and a per-net select mask limits which nets are judged. The result is a mask of faulty nets and a single pass flag. A one-cycle done pulse marks the moment these outputs become valid. The outputs then hold until the next run finishes. Start and done are plain control pins with no back-pressure: a start seen while a run is active is dropped, and results need no acknowledge.

Top module: `bscan_net_tester`

## Requirements
- R1: During and after reset, tck is 0, tms is 1, tdi is 0, done is 0, pass is 0 and fault_mask is all zeros.
- R2: While a run is active, tck toggles every HALF_DIV system clocks, so consecutive rising edges lie 2*HALF_DIV clocks apart. Between runs, and whenever done is high, tck is held at 0.
- R3: tms and tdi change only in a system cycle where tck is low, which means only on a falling edge or at run start. tdo is sampled at the system edge where tck rises.
- R4: Each run opens with RST_CYC rising tck edges with tms at 1, followed by one edge with tms at 0 that moves the controllers to Run-Test/Idle.
- R5: The instruction IR_CODE is shifted through Shift-IR least significant bit first. Its last bit is sent with tms at 1, and an Update-IR step follows, so the chain's instruction register holds IR_CODE afterwards.
- R6: The drive vector is shifted into Shift-DR least significant bit first, so bit k reaches the cell of net k. It reaches the pins only through Update-DR. During a run the pins take only the drive vector's value, and exactly two Update-DR steps happen.
- R7: A Capture-DR step then loads the pin levels, and NETS bits are shifted out. The bit sampled on the k-th Shift-DR rising edge is the level of net k. A run takes exactly RST_CYC+1+4+IR_LEN+2+2*(NETS+5) rising tck edges.
- R8: fault_mask equals (captured XOR expected) AND select. pass is 1 exactly when fault_mask is zero.
- R9: done is high for one system cycle, in the first cycle where pass and fault_mask show the new result. Both outputs hold until the next run completes.
- R10: A start request that arrives while a run is in progress has no effect: the run completes with the same edge count and a single done pulse.
- R11: drive_vec, expect_vec and select_vec are sampled in the cycle a start is accepted. Later changes do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, accepted only when idle |
| drive_vec | input | NETS | Values to drive onto the nets |
| expect_vec | input | NETS | Levels expected back from the nets |
| select_vec | input | NETS | Nets that take part in the comparison |
| tdo | input | 1 | Serial data returning from the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data into the chain |
| done | output | 1 | One-cycle pulse when the result is valid |
| pass | output | 1 | High when no selected net mismatches |
| fault_mask | output | NETS | One bit per net that read back wrong |

## Verification
The assertions assume that select_vec stays unchanged from an accepted start until the matching done pulse. They also assume that tdo, which the chain drives, changes only on falling tck edges. The bench supplies tdo from a behavioural chain controller that updates its output on tck's falling edge, so the second assumption always holds. The bench holds select_vec steady through every run, including the case that alters drive_vec and expect_vec mid-run to probe sampling at start.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RST,
    PH_RTI,
    PH_IR_PRE,
    PH_IR_SH,
    PH_IR_POST,
    PH_DR_PRE,
    PH_DR_SH,
    PH_DR_POST,
    PH_FIN,
    PH_CMP
  } phase_e;

  localparam int unsigned IR_PRE_STEPS = 4;  // 1,1,0,0 : Idle -> Shift-IR
  localparam int unsigned DR_PRE_STEPS = 3;  // 1,0,0   : Idle -> Shift-DR
  localparam int unsigned POST_STEPS   = 2;  // 1,0     : Exit1 -> Update -> Idle

  function automatic int unsigned run_rises(input int unsigned rst_cyc,
                                            input int unsigned ir_len,
                                            input int unsigned nets);
    return rst_cyc + 1 + IR_PRE_STEPS + ir_len + POST_STEPS
           + 2 * (DR_PRE_STEPS + nets + POST_STEPS);
  endfunction

endpackage

// File: rtl/bscan_tck_div.sv
module bscan_tck_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic rise_evt,
  output logic fall_evt
);

  logic wrap;

  generate
    if (HALF_DIV <= 1) begin : g_fast
      assign wrap = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign wrap = run && (cnt == LAST);
    end
  endgenerate

  assign rise_evt = wrap && !tck;
  assign fall_evt = wrap && tck;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) tck <= 1'b0;
    else if (wrap) tck <= ~tck;
  end

endmodule

// File: rtl/bscan_seq.sv
module bscan_seq
  import bscan_pkg::*;
#(
  parameter int unsigned NETS = 8,
  parameter int unsigned IR_LEN = 4,
  parameter logic [IR_LEN-1:0] IR_CODE = '0,
  parameter int unsigned RST_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NETS-1:0] drive_vec,
  input  logic            rise_evt,
  input  logic            fall_evt,
  output logic            start_acc,
  output logic            run_tck,
  output logic            tms,
  output logic            tdi,
  output logic            cap_en,
  output logic            cmp_go
);

  localparam int unsigned M1 = (RST_CYC > IR_LEN) ? RST_CYC : IR_LEN;
  localparam int unsigned M2 = (M1 > NETS) ? M1 : NETS;
  localparam int unsigned CNT_MAX = (M2 > IR_PRE_STEPS) ? M2 : IR_PRE_STEPS;
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  phase_e            phase, phase_nx;
  logic [CNT_W-1:0]  cnt, limit;
  logic              last, rd;
  logic [IR_LEN-1:0] ir_rot;
  logic [NETS-1:0]   drv_rot;
  logic              tms_n, tdi_n;

  // Steps per phase (count - 1) and successor phase
  always_comb begin
    limit    = '0;
    phase_nx = phase;
    unique case (phase)
      PH_RST:     begin limit = CNT_W'(RST_CYC - 1);      phase_nx = PH_RTI;     end
      PH_RTI:     begin limit = '0;                       phase_nx = PH_IR_PRE;  end
      PH_IR_PRE:  begin limit = CNT_W'(IR_PRE_STEPS - 1); phase_nx = PH_IR_SH;   end
      PH_IR_SH:   begin limit = CNT_W'(IR_LEN - 1);       phase_nx = PH_IR_POST; end
      PH_IR_POST: begin limit = CNT_W'(POST_STEPS - 1);   phase_nx = PH_DR_PRE;  end
      PH_DR_PRE:  begin limit = CNT_W'(DR_PRE_STEPS - 1); phase_nx = PH_DR_SH;   end
      PH_DR_SH:   begin limit = CNT_W'(NETS - 1);         phase_nx = PH_DR_POST; end
      PH_DR_POST: begin
        limit    = CNT_W'(POST_STEPS - 1);
        phase_nx = rd ? PH_FIN : PH_DR_PRE;
      end
      default: ;
    endcase
  end

  assign last = (cnt == limit);

  // Pin values for the current step
  always_comb begin
    tms_n = 1'b0;
    tdi_n = 1'b0;
    unique case (phase)
      PH_RST:     tms_n = 1'b1;
      PH_IR_PRE:  tms_n = (cnt < CNT_W'(2));
      PH_IR_SH:   begin tms_n = last; tdi_n = ir_rot[0]; end
      PH_IR_POST: tms_n = (cnt == '0);
      PH_DR_PRE:  tms_n = (cnt == '0);
      PH_DR_SH:   begin tms_n = last; tdi_n = drv_rot[0]; end
      PH_DR_POST: tms_n = (cnt == '0);
      default: ;
    endcase
  end

  assign start_acc = start && (phase == PH_IDLE);
  assign run_tck   = (phase != PH_IDLE) && (phase != PH_CMP);
  assign cap_en    = rise_evt && (phase == PH_DR_SH) && rd;
  assign cmp_go    = (phase == PH_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rd      <= 1'b0;
      ir_rot  <= '0;
      drv_rot <= '0;
      tms     <= 1'b1;
      tdi     <= 1'b0;
    end else if (start_acc) begin
      phase   <= PH_RST;
      cnt     <= '0;
      rd      <= 1'b0;
      ir_rot  <= IR_CODE;
      drv_rot <= drive_vec;
      tms     <= 1'b1;
      tdi     <= 1'b0;
    end else begin
      if (fall_evt) begin
        tms <= tms_n;
        tdi <= tdi_n;
        if (phase == PH_FIN) phase <= PH_CMP;
      end
      if (phase == PH_CMP) phase <= PH_IDLE;
      if (rise_evt && phase != PH_FIN) begin
        if (phase == PH_IR_SH) ir_rot <= {ir_rot[0], ir_rot[IR_LEN-1:1]};
        if (phase == PH_DR_SH) drv_rot <= {drv_rot[0], drv_rot[NETS-1:1]};
        if (last) begin
          cnt   <= '0;
          phase <= phase_nx;
          if (phase == PH_DR_POST) rd <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bscan_cmp.sv
module bscan_cmp #(
  parameter int unsigned NETS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_acc,
  input  logic [NETS-1:0] expect_vec,
  input  logic [NETS-1:0] select_vec,
  input  logic            cap_en,
  input  logic            tdo,
  input  logic            cmp_go,
  output logic            done,
  output logic            pass,
  output logic [NETS-1:0] fault_mask
);

  logic [NETS-1:0] exp_q, sel_q, cap_q, diff;

  assign diff = (cap_q ^ exp_q) & sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q      <= '0;
      sel_q      <= '0;
      cap_q      <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      fault_mask <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        exp_q <= expect_vec;
        sel_q <= select_vec;
      end
      if (cap_en) cap_q <= {tdo, cap_q[NETS-1:1]};  // first bit ends in bit 0
      if (cmp_go) begin
        fault_mask <= diff;
        pass       <= (diff == '0);
        done       <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bscan_net_tester.sv
module bscan_net_tester #(
  parameter int unsigned NETS = 8,
  parameter int unsigned IR_LEN = 4,
  parameter logic [IR_LEN-1:0] IR_CODE = 4'b0110,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned RST_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NETS-1:0] drive_vec,
  input  logic [NETS-1:0] expect_vec,
  input  logic [NETS-1:0] select_vec,
  input  logic            tdo,
  output logic            tck,
  output logic            tms,
  output logic            tdi,
  output logic            done,
  output logic            pass,
  output logic [NETS-1:0] fault_mask
);

  logic start_acc, run_tck, rise_evt, fall_evt, cap_en, cmp_go;

  bscan_tck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_tck),
    .tck      (tck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  bscan_seq #(
    .NETS(NETS), .IR_LEN(IR_LEN), .IR_CODE(IR_CODE), .RST_CYC(RST_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .drive_vec (drive_vec),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .start_acc (start_acc),
    .run_tck   (run_tck),
    .tms       (tms),
    .tdi       (tdi),
    .cap_en    (cap_en),
    .cmp_go    (cmp_go)
  );

  bscan_cmp #(.NETS(NETS)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc  (start_acc),
    .expect_vec (expect_vec),
    .select_vec (select_vec),
    .cap_en     (cap_en),
    .tdo        (tdo),
    .cmp_go     (cmp_go),
    .done       (done),
    .pass       (pass),
    .fault_mask (fault_mask)
  );

endmodule

// File: rtl/bscan_net_tester_chk.sv
module bscan_net_tester_chk
  import bscan_pkg::*;
#(
  parameter int unsigned NETS = 8,
  parameter int unsigned IR_LEN = 4,
  parameter int unsigned RST_CYC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tck,
  input logic            tms,
  input logic            tdi,
  input logic            done,
  input logic            pass,
  input logic [NETS-1:0] fault_mask,
  input logic [NETS-1:0] select_vec
);

  localparam int unsigned TOTAL = run_rises(RST_CYC, IR_LEN, NETS);

  logic        tck_d;
  logic [15:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tck_d <= 1'b0;
      rises <= '0;
    end else begin
      tck_d <= tck;
      if (done) rises <= '0;
      else if (tck && !tck_d) rises <= rises + 1'b1;
    end
  end

  AST_TMS_TDI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));  // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_PASS_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (fault_mask == '0)));  // R8

  AST_MASK_WITHIN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fault_mask & ~select_vec) == '0));  // R8

  AST_TCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tck);  // R2

  AST_RUN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == 16'(TOTAL)));  // R7

endmodule

bind bscan_net_tester bscan_net_tester_chk #(
  .NETS(NETS), .IR_LEN(IR_LEN), .RST_CYC(RST_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tck        (tck),
  .tms        (tms),
  .tdi        (tdi),
  .done       (done),
  .pass       (pass),
  .fault_mask (fault_mask),
  .select_vec (select_vec)
);

// File: tb/bscan_net_tester_test.sv
`timescale 1ns/1ps
module bscan_net_tester_test;

  localparam int unsigned NETS = 8;
  localparam int unsigned IRL = 4;
  localparam logic [IRL-1:0] CODE = 4'b0110;
  localparam int unsigned HALF = 2;
  localparam int unsigned RSTC = 5;
  localparam int unsigned TOTAL = RSTC + 1 + 4 + IRL + 2 + 2 * (3 + NETS + 2);

  typedef enum logic [3:0] {TLR, RTI, SDS, CDR, SDR, E1D, PDR, E2D, UDR,
                            SIS, CIR, SIR, E1I, PIR, E2I, UIR} tap_e;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NETS-1:0] drive_vec = '0, expect_vec = '0, select_vec = '0;
  logic tck, tms, tdi, done, pass;
  logic [NETS-1:0] fault_mask;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  // ---------------- behavioural chain controller ----------------
  tap_e ts = TLR;
  logic [IRL-1:0] ir = '1, ir_sh = '0;
  logic [NETS-1:0] bsr = '0, upd = '0, s0 = '0, s1 = '0, cur_drv = '0;
  logic byp = 1'b0, m_tdo = 1'b0;
  int upd_cnt = 0, bad_upd = 0, rise_idx = 0;
  logic [7:0] lead = '0;
  wire [NETS-1:0] pins_in = (upd & ~s0) | s1;

  function automatic tap_e nxt(input tap_e s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;
      SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    case (ts)
      TLR: ir <= '1;
      CDR: if (ir == CODE) bsr <= pins_in; else byp <= 1'b0;
      SDR: if (ir == CODE) bsr <= {tdi, bsr[NETS-1:1]}; else byp <= tdi;
      UDR: if (ir == CODE) begin
        upd <= bsr;
        upd_cnt <= upd_cnt + 1;
        if (bsr != cur_drv) bad_upd <= bad_upd + 1;
      end
      CIR: ir_sh <= IRL'(1);
      SIR: ir_sh <= {tdi, ir_sh[IRL-1:1]};
      UIR: ir <= ir_sh;
      default: ;
    endcase
    if (rise_idx < 8) lead[rise_idx] <= tms;
    rise_idx <= rise_idx + 1;
    ts <= nxt(ts, tms);
  end

  always @(negedge tck) begin
    if (ts == SDR) m_tdo <= (ir == CODE) ? bsr[0] : byp;
    else if (ts == SIR) m_tdo <= ir_sh[0];
  end

  bscan_net_tester #(
    .NETS(NETS), .IR_LEN(IRL), .IR_CODE(CODE), .HALF_DIV(HALF), .RST_CYC(RSTC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .drive_vec(drive_vec),
    .expect_vec(expect_vec), .select_vec(select_vec), .tdo(m_tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .done(done), .pass(pass),
    .fault_mask(fault_mask)
  );

  // ---------------- clock-level monitors ----------------
  logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0, have_prev = 1'b0;
  int gap = 0, r2_viol = 0, r3_viol = 0, rises = 0, done_cnt = 0, cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((tms != p_tms || tdi != p_tdi) && tck) r3_viol <= r3_viol + 1;
      if (tck && !p_tck) begin
        if (have_prev && gap != 2 * HALF) r2_viol <= r2_viol + 1;
        have_prev <= 1'b1;
        gap <= 1;
        rises <= rises + 1;
      end else begin
        gap <= gap + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
    end
    p_tck <= tck; p_tms <= tms; p_tdi <= tdi;
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung act=%0d exp<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic reset_case();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(tck == 1'b0, "R1 tck in reset", 32'(tck), 0);
    check(tms == 1'b1 && tdi == 1'b0, "R1 tms/tdi in reset", {tms, tdi}, 2'b10);
    check(done == 1'b0 && pass == 1'b0, "R1 done/pass in reset", {done, pass}, 0);
    check(fault_mask == '0, "R1 mask in reset", 32'(fault_mask), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tck == 1'b0 && done == 1'b0, "R1 idle after reset", {tck, done}, 0);
  endtask

  task automatic run_case(input string name, input logic [NETS-1:0] drv,
                          input logic [NETS-1:0] exp, input logic [NETS-1:0] sel,
                          input logic [NETS-1:0] f0, input logic [NETS-1:0] f1,
                          input bit poke);
    logic [NETS-1:0] want;
    bit seen;
    want = (((drv & ~f0) | f1) ^ exp) & sel;
    s0 = f0; s1 = f1; cur_drv = drv;
    upd_cnt = 0; bad_upd = 0; rise_idx = 0; lead = '0;
    have_prev = 1'b0; rises = 0; done_cnt = 0; r2_viol = 0; r3_viol = 0;
    @(negedge clk);
    drive_vec = drv; expect_vec = exp; select_vec = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1; drive_vec = ~drv; expect_vec = ~exp;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, {"R9 done seen ", name}, 32'(seen), 1);
    check(fault_mask == want, {"R8 mask ", name}, 32'(fault_mask), 32'(want));
    check(pass == (want == '0), {"R8 pass ", name}, 32'(pass), 32'(want == '0));
    check(tck == 1'b0, {"R2 tck low at done ", name}, 32'(tck), 0);
    repeat (20) @(negedge clk);
    check(done_cnt == 1, {"R9 R10 single done ", name}, 32'(done_cnt), 1);
    check(fault_mask == want && pass == (want == '0), {"R9 result held ", name},
          32'(fault_mask), 32'(want));
    check(rises == TOTAL, {"R7 R10 tck rises ", name}, 32'(rises), 32'(TOTAL));
    check(r2_viol == 0, {"R2 tck period ", name}, 32'(r2_viol), 0);
    check(r3_viol == 0, {"R3 tms/tdi on low tck ", name}, 32'(r3_viol), 0);
    check(lead[5:0] == 6'b011111, {"R4 reset prologue ", name}, 32'(lead[5:0]), 32'h1f);
    check(ir == CODE && ts == RTI, {"R5 instruction loaded ", name}, {ir, ts}, {CODE, RTI});
    check(upd_cnt == 2 && bad_upd == 0, {"R6 R11 pin updates ", name},
          32'(upd_cnt * 256 + bad_upd), 32'(2 * 256));
    check(upd == drv, {"R6 pins hold drive ", name}, 32'(upd), 32'(drv));
  endtask

  initial begin
    reset_case();
    run_case("clean", 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0);
    run_case("open3", 8'hFF, 8'hFF, 8'hFF, 8'h08, 8'h00, 1'b0);
    run_case("mixed", 8'hA5, 8'hA5, 8'hFF, 8'h80, 8'h02, 1'b0);
    run_case("masked", 8'hA5, 8'hA5, 8'h7D, 8'h80, 8'h02, 1'b0);
    run_case("lsb", 8'h01, 8'h80, 8'hFF, 8'h00, 8'h00, 1'b0);  // R7 bit order
    run_case("busy", 8'h3C, 8'h3C, 8'hFF, 8'h04, 8'h00, 1'b1); // R10 R11
    summary();
    $finish;
  end

endmodule